// File: doc/BRIEF.md
# IDE Bus-Master DMA Register Front End

This block is the host-facing register set of one bus-master IDE DMA channel. It keeps a command byte, a status byte and a 32-bit base pointer to the descriptor table in memory. The host reaches them through a byte-addressed port. Each access starts at a byte offset and covers 1, 2 or 4 bytes. The descriptor walker that moves the data sits beside this block. It gets a table-pointer load strobe, a transfer kick strobe, a cancel strobe, the direction bit and the base pointer. It reports back when a transfer ends and whether more remain.

The start bit in the command byte works on edges. A write that leaves the start bit as it was does nothing beyond storing the byte. A rising start bit makes the walker reload its table pointer from the base register. It also kicks the walker when no transfer is marked active. A falling start bit cancels the walker and clears the active flag.

The drive interrupt goes straight through to the host. Each rising edge of it also latches the interrupt flag in status. The host clears that flag, and the error flag, by writing ones to them.

Top module: `bmdma_regs`

## Requirements
- R1: A write that covers byte 0 stores its low byte ANDed with 0x09 as the command byte: bit 0 is start and bit 3 is direction. `dma_dir` follows stored bit 3.
- R2: A write that turns start from 0 to 1 pulses `tbl_load` for one cycle, in the cycle after the write edge. In that same cycle `xfer_kick` also pulses, but only if status bit 0 (active) was clear. Active is set.
- R3: A command write that keeps the start bit unchanged produces no strobe and leaves the active bit unchanged.
- R4: A write that turns start from 1 to 0 pulses `xfer_cancel` in the cycle after the write edge and clears the active bit.
- R5: A write merges into the base pointer only the bytes it covers at byte offsets 4 to 7. Bits 1:0 of the pointer are always zero. The pointer is driven on `tbl_base`.
- R6: `reg_rdata` is a little-endian image shifted right by 8 times `reg_off`, with bytes at or above `reg_size` read as zero. In the image, byte 0 holds command, byte 2 holds status, bytes 4 to 7 hold the base pointer, and every other byte reads zero.
- R7: Status bit 1 (error) and bit 2 (interrupt) clear when a write covering byte 2 carries a one in that bit. Bit 0 cannot be changed by a status write. Bits 7:3 read zero.
- R8: `host_irq` equals `drv_irq` at all times. A rising edge of `drv_irq` sets status bit 2. If that edge meets a clearing write in the same cycle, the bit ends up set.
- R9: When `xfer_done` is high, active becomes `xfer_more`. A start-bit change written in the same cycle takes priority over it.
- R10: `xfer_err` sets status bit 1. If it meets a clearing write in the same cycle, the bit ends up set.
- R11: Reset clears command, status and base pointer. If active was set when reset is first sampled, `xfer_cancel` pulses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 3 | Byte offset of the access |
| reg_size | input | 3 | Access width in bytes (1, 2 or 4) |
| reg_wdata | input | 32 | Write data, lowest byte at `reg_off` |
| reg_rdata | output | 32 | Read data for `reg_off`/`reg_size` |
| drv_irq | input | 1 | Interrupt line from the drive |
| host_irq | output | 1 | Interrupt line to the host |
| xfer_done | input | 1 | Walker reports the end of a transfer |
| xfer_more | input | 1 | With `xfer_done`: further transfers remain |
| xfer_err | input | 1 | Walker reports an error |
| dma_dir | output | 1 | Stored direction bit |
| tbl_base | output | 32 | Descriptor table base pointer |
| tbl_load | output | 1 | Reload table pointer from base |
| xfer_kick | output | 1 | Start a pending transfer |
| xfer_cancel | output | 1 | Abort the transfer in flight |

## Verification
Two collisions are provoked on purpose. In the first, a rising edge of the drive interrupt lands in the same cycle as a host write that clears the interrupt bit. In the second, the walker's end-of-transfer report with more-pending lands in the same cycle as a command write that drops start. The bench holds both inputs on one clock edge, then reads status back through the register port. The interrupt bit must stay set, and active must be clear with a cancel strobe. Error reports are also driven against write-one-to-clear writes across the whole offset and size sweep, which covers that collision as well.

// File: rtl/bmdma_pkg.sv
// Shared layout constants for the bus-master DMA register front end.
// Assumes a little-endian byte image of eight bytes per channel.
package bmdma_pkg;
    localparam int CMD_LANE  = 0;
    localparam int STAT_LANE = 2;
    localparam int BASE_LANE = 4;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;
    localparam logic [7:0] CMD_KEEP = 8'h09;

    localparam int ST_ACT = 0;
    localparam int ST_ERR = 1;
    localparam int ST_INT = 2;
endpackage

// File: rtl/bmdma_lane_dec.sv
// Byte-lane decoder: turns (offset, size, data) into per-lane write enables
// and a lane-aligned write image. It also extracts read data from the
// register image. Assumes size is 1, 2 or 4 and BUS_BYTES is a power of two.
module bmdma_lane_dec #(
    parameter int BUS_BYTES = 4,
    parameter int MAP_BYTES = 8,
    parameter int OFF_W     = 3,
    parameter int SZ_W      = 3
) (
    input  logic                   wr,
    input  logic [OFF_W-1:0]       off,
    input  logic [SZ_W-1:0]        size,
    input  logic [8*BUS_BYTES-1:0] wdata,
    input  logic [8*MAP_BYTES-1:0] img,
    output logic [MAP_BYTES-1:0]   be,
    output logic [8*MAP_BYTES-1:0] wimg,
    output logic [8*BUS_BYTES-1:0] rdata
);
    localparam int BUS_W = 8 * BUS_BYTES;
    localparam int MAP_W = 8 * MAP_BYTES;

    logic [MAP_W-1:0] shifted;

    // Place write data at its byte offset within the map image.
    assign wimg    = {{(MAP_W-BUS_W){1'b0}}, wdata} << {off, 3'b000};
    // Bring the addressed byte down to lane 0 for reading.
    assign shifted = img >> {off, 3'b000};

    for (genvar i = 0; i < MAP_BYTES; i++) begin : g_be
        // Lane i is written when it falls within [off, off+size).
        assign be[i] = wr && (int'(off) <= i) && (i < int'(off) + int'(size));
    end

    for (genvar j = 0; j < BUS_BYTES; j++) begin : g_rd
        // Read lanes at or above the access size return zero.
        assign rdata[8*j +: 8] = (j < int'(size)) ? shifted[8*j +: 8] : 8'h00;
    end
endmodule

// File: rtl/bmdma_cmd_ctl.sv
// Command byte and start-edge control. Stores the masked command byte and
// detects start-bit transitions. Registers one-cycle strobes for table
// reload, kick and cancel. Assumes act_i is the registered active flag.
module bmdma_cmd_ctl
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wbyte,
    input  logic       act_i,
    output logic [7:0] cmd_q,
    output logic       go_rise,
    output logic       go_fall,
    output logic       load_q,
    output logic       kick_q,
    output logic       cancel_q
);
    // Decode a change of the start bit on this write.
    always_comb begin
        go_rise = we &&  wbyte[CMD_GO] && !cmd_q[CMD_GO];
        go_fall = we && !wbyte[CMD_GO] &&  cmd_q[CMD_GO];
    end

    // Hold the command byte and emit the walker strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            load_q   <= 1'b0;
            kick_q   <= 1'b0;
            cancel_q <= act_i;
        end else begin
            if (we) begin
                cmd_q <= wbyte & CMD_KEEP;
            end
            load_q   <= go_rise;
            kick_q   <= go_rise && !act_i;
            cancel_q <= go_fall;
        end
    end
endmodule

// File: rtl/bmdma_status.sv
// Status byte: active flag driven by start edges and transfer completion.
// Error and interrupt flags are sticky and cleared by writing ones.
// Assumes a set event wins over a clear in the same cycle.
module bmdma_status
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_rise,
    input  logic       go_fall,
    input  logic       done,
    input  logic       more,
    input  logic       err,
    input  logic       irq,
    input  logic       we,
    input  logic [7:0] wbyte,
    output logic [7:0] stat_q
);
    logic act_q, err_q, int_q, irq_prev;
    logic irq_up;

    // Detect a rising edge of the drive interrupt.
    assign irq_up = irq && !irq_prev;

    // Update the three status flags and the edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            err_q    <= 1'b0;
            int_q    <= 1'b0;
            irq_prev <= 1'b0;
        end else begin
            if (go_fall) begin
                act_q <= 1'b0;
            end else if (go_rise) begin
                act_q <= 1'b1;
            end else if (done) begin
                act_q <= more;
            end
            err_q    <= err    || (err_q && !(we && wbyte[ST_ERR]));
            int_q    <= irq_up || (int_q && !(we && wbyte[ST_INT]));
            irq_prev <= irq;
        end
    end

    // Assemble the status byte; unused bits read zero.
    always_comb begin
        stat_q         = '0;
        stat_q[ST_ACT] = act_q;
        stat_q[ST_ERR] = err_q;
        stat_q[ST_INT] = int_q;
    end
endmodule

// File: rtl/bmdma_base_reg.sv
// Descriptor table base pointer with byte-lane merge. The two low
// bits are held at zero so the pointer stays dword aligned.
module bmdma_base_reg #(
    parameter int MAP_BYTES  = 8,
    parameter int FIRST_LANE = 4,
    parameter int ADDR_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [MAP_BYTES-1:0]    be,
    input  logic [8*MAP_BYTES-1:0]  wimg,
    output logic [8*ADDR_BYTES-1:0] base_q
);
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_byte
        localparam logic [7:0] KEEP = (k == 0) ? 8'hFC : 8'hFF;
        // Merge one byte of the pointer when its lane is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[8*k +: 8] <= 8'h00;
            end else if (be[FIRST_LANE + k]) begin
                base_q[8*k +: 8] <= wimg[8*(FIRST_LANE + k) +: 8] & KEEP;
            end
        end
    end
endmodule

// File: rtl/bmdma_regs.sv
// Top of the bus-master DMA register front end. Decodes byte-lane accesses
// into command, status and base pointer. Forwards the drive interrupt and
// drives the walker strobes. Assumes one access per cycle, reads combinational.
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int BUS_BYTES  = 4,
    parameter int ADDR_BYTES = 4,
    localparam int MAP_BYTES = BASE_LANE + ADDR_BYTES,
    localparam int OFF_W     = $clog2(MAP_BYTES),
    localparam int SZ_W      = $clog2(BUS_BYTES) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [OFF_W-1:0]        reg_off,
    input  logic [SZ_W-1:0]         reg_size,
    input  logic [8*BUS_BYTES-1:0]  reg_wdata,
    output logic [8*BUS_BYTES-1:0]  reg_rdata,
    input  logic                    drv_irq,
    output logic                    host_irq,
    input  logic                    xfer_done,
    input  logic                    xfer_more,
    input  logic                    xfer_err,
    output logic                    dma_dir,
    output logic [8*ADDR_BYTES-1:0] tbl_base,
    output logic                    tbl_load,
    output logic                    xfer_kick,
    output logic                    xfer_cancel
);
    logic [MAP_BYTES-1:0]   be;
    logic [8*MAP_BYTES-1:0] wimg, img;
    logic [7:0] cmd_q, stat_q, cmd_wbyte, stat_wbyte;
    logic       cmd_we, stat_we, go_rise, go_fall;
    logic [8*ADDR_BYTES-1:0] base_q;

    bmdma_lane_dec #(
        .BUS_BYTES(BUS_BYTES), .MAP_BYTES(MAP_BYTES), .OFF_W(OFF_W), .SZ_W(SZ_W)
    ) u_dec (
        .wr(reg_wr), .off(reg_off), .size(reg_size), .wdata(reg_wdata),
        .img(img), .be(be), .wimg(wimg), .rdata(reg_rdata)
    );

    // Pick out the lanes that belong to command and status.
    always_comb begin
        cmd_we     = be[CMD_LANE];
        cmd_wbyte  = wimg[8*CMD_LANE +: 8];
        stat_we    = be[STAT_LANE];
        stat_wbyte = wimg[8*STAT_LANE +: 8];
    end

    bmdma_cmd_ctl u_cmd (
        .clk(clk), .rst_n(rst_n), .we(cmd_we), .wbyte(cmd_wbyte),
        .act_i(stat_q[ST_ACT]), .cmd_q(cmd_q), .go_rise(go_rise),
        .go_fall(go_fall), .load_q(tbl_load), .kick_q(xfer_kick),
        .cancel_q(xfer_cancel)
    );

    bmdma_status u_stat (
        .clk(clk), .rst_n(rst_n), .go_rise(go_rise), .go_fall(go_fall),
        .done(xfer_done), .more(xfer_more), .err(xfer_err), .irq(drv_irq),
        .we(stat_we), .wbyte(stat_wbyte), .stat_q(stat_q)
    );

    bmdma_base_reg #(
        .MAP_BYTES(MAP_BYTES), .FIRST_LANE(BASE_LANE), .ADDR_BYTES(ADDR_BYTES)
    ) u_base (
        .clk(clk), .rst_n(rst_n), .be(be), .wimg(wimg), .base_q(base_q)
    );

    // Build the readable register image; unmapped bytes are zero.
    always_comb begin
        img = '0;
        img[8*CMD_LANE  +: 8]            = cmd_q;
        img[8*STAT_LANE +: 8]            = stat_q;
        img[8*BASE_LANE +: 8*ADDR_BYTES] = base_q;
    end

    // Drive the walker-facing and host-facing outputs.
    always_comb begin
        host_irq = drv_irq;
        dma_dir  = cmd_q[CMD_DIR];
        tbl_base = base_q;
    end
endmodule

// File: rtl/bmdma_regs_chk.sv
// Protocol checker for bmdma_regs. Relates command writes, the walker
// strobes and status over time. Attached to every instance by bind.
module bmdma_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic [7:0] cmd_wbyte,
    input logic [7:0] cmd_q,
    input logic [7:0] stat_q,
    input logic       drv_irq,
    input logic       xfer_done,
    input logic       xfer_more,
    input logic       load,
    input logic       kick,
    input logic       cancel
);
    assert_cmd_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> cmd_q == ($past(cmd_wbyte) & 8'h09));

    assert_kick_has_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> load);

    assert_same_start_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && (cmd_wbyte[0] == cmd_q[0])) |=> (!kick && !load && !cancel));

    assert_cancel_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> !stat_q[0]);

    assert_irq_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_irq) |=> stat_q[2]);

    assert_last_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !xfer_more && !cmd_we) |=> !stat_q[0]);
endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wbyte(cmd_wbyte),
    .cmd_q(cmd_q), .stat_q(stat_q), .drv_irq(drv_irq), .xfer_done(xfer_done),
    .xfer_more(xfer_more), .load(tbl_load), .kick(xfer_kick), .cancel(xfer_cancel)
);

// File: tb/tb_bmdma_regs.sv
// Self-checking bench: sweeps command values, every offset/size pair and
// status collisions against an arithmetic model of the register image.
module tb_bmdma_regs;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst_n, reg_wr, drv_irq, host_irq, xfer_done, xfer_more, xfer_err;
    logic [2:0]  reg_off, reg_size;
    logic [31:0] reg_wdata, reg_rdata, tbl_base;
    logic        dma_dir, tbl_load, xfer_kick, xfer_cancel;

    bmdma_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .drv_irq(drv_irq), .host_irq(host_irq), .xfer_done(xfer_done),
        .xfer_more(xfer_more), .xfer_err(xfer_err), .dma_dir(dma_dir),
        .tbl_base(tbl_base), .tbl_load(tbl_load), .xfer_kick(xfer_kick),
        .xfer_cancel(xfer_cancel)
    );

    int vecs = 0;
    int errs = 0;
    logic [7:0]  m_cmd;
    logic [31:0] m_base;
    logic        m_act, m_err, m_int, m_prev;

    function automatic logic [63:0] m_img();
        return {m_base, 8'h00, 5'b0, m_int, m_err, m_act, 8'h00, m_cmd};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock of stimulus from a falling edge; checks strobes after it.
    task automatic step(input bit wr, input int off, input int sz, input logic [31:0] d,
                        input bit done, input bit more, input bit err, input bit irq);
        logic [63:0] wi;
        logic [7:0]  sb;
        bit cw, sw, rise, fall;
        logic [2:0] ep;
        string tag;
        reg_wr = wr; reg_off = off[2:0]; reg_size = sz[2:0]; reg_wdata = d;
        xfer_done = done; xfer_more = more; xfer_err = err; drv_irq = irq;
        wi   = {32'h0, d} << (8 * off);
        cw   = wr && (off == 0);
        sw   = wr && (off <= 2) && (2 < off + sz);
        sb   = wi[23:16];
        rise = cw &&  wi[0] && !m_cmd[0];
        fall = cw && !wi[0] &&  m_cmd[0];
        ep   = {rise && !m_act, rise, fall};
        tag  = rise ? "R2" : (fall ? "R4" : "R3");
        m_act = fall ? 1'b0 : (rise ? 1'b1 : (done ? more : m_act));
        m_err = err || (m_err && !(sw && sb[1]));
        m_int = (irq && !m_prev) || (m_int && !(sw && sb[2]));
        m_prev = irq;
        if (cw) m_cmd = wi[7:0] & 8'h09;
        for (int i = 4; i < 8; i++)
            if (wr && off <= i && i < off + sz) m_base[8*(i-4) +: 8] = wi[8*i +: 8];
        m_base[1:0] = 2'b00;
        @(posedge clk);
        @(negedge clk);
        chk(tag, {61'b0, xfer_kick, tbl_load, xfer_cancel}, {61'b0, ep});
        chk("R8", host_irq, irq);
        chk("R1", dma_dir, m_cmd[3]);
        chk("R5", tbl_base, m_base);
        reg_wr = 0; xfer_done = 0; xfer_err = 0;
    endtask

    task automatic rd_sweep(input string tag);
        logic [63:0] e;
        for (int off = 0; off < 8; off++) begin
            for (int si = 0; si < 3; si++) begin
                reg_off = off[2:0]; reg_size = 3'(1 << si);
                #1;
                e = (m_img() >> (8 * off)) & ((64'h1 << (8 << si)) - 1);
                chk(tag, reg_rdata, e);
            end
        end
    endtask

    task automatic rd_quick(input string tag);
        reg_off = 3'd0; reg_size = 3'd4; #1;
        chk(tag, reg_rdata, m_img() & 64'hFFFF_FFFF);
        reg_off = 3'd4; #1;
        chk(tag, reg_rdata, m_img() >> 32);
    endtask

    task automatic do_reset();
        logic exp_c;
        exp_c = m_act;
        rst_n = 0; reg_wr = 0; xfer_done = 0; xfer_err = 0; drv_irq = 0;
        @(posedge clk); @(negedge clk);
        chk("R11", xfer_cancel, exp_c);
        @(posedge clk); @(negedge clk);
        rst_n = 1;
        m_cmd = 0; m_base = 0; m_act = 0; m_err = 0; m_int = 0; m_prev = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        rst_n = 0; reg_wr = 0; reg_off = 0; reg_size = 1; reg_wdata = 0;
        drv_irq = 0; xfer_done = 0; xfer_more = 0; xfer_err = 0;
        m_cmd = 0; m_base = 0; m_act = 0; m_err = 0; m_int = 0; m_prev = 0;
        @(negedge clk);
        do_reset();
        rd_sweep("R11");

        // R1 R2 R3 R4: every command byte, with active preset either way.
        for (int v = 0; v < 256; v++) begin
            step(0, 0, 1, 0, 1, v[5], 0, 0);
            step(1, 0, 1, 32'(v) | 32'h0000_FF00, 0, 0, 0, 0);
            rd_quick("R1");
        end

        // R5 R6 R7 R10: every offset and size, flags raised before each write.
        for (int p = 0; p < 4; p++) begin
            for (int off = 0; off < 8; off++) begin
                for (int si = 0; si < 3; si++) begin
                    if (off + (1 << si) <= 8) begin
                        step(0, 0, 1, 0, 0, 0, 1, 1);
                        step(1, off, 1 << si, 32'h9E37_79B9 * 32'(p*24 + off*3 + si + 1),
                             0, 0, p[1], p[0]);
                        if (p == 0) rd_sweep("R6"); else rd_quick("R7");
                    end
                end
            end
        end

        // R8: drive interrupt edge meets a clear of the interrupt bit.
        step(0, 0, 1, 0, 0, 0, 0, 0);
        step(1, 2, 1, 32'h0000_0004, 0, 0, 0, 1);
        rd_quick("R8");
        step(1, 2, 1, 32'h0000_0004, 0, 0, 0, 1);
        rd_quick("R8");

        // R10: error report meets a clear of the error bit.
        step(1, 2, 1, 32'h0000_0002, 0, 0, 1, 0);
        rd_quick("R10");

        // R9: stop written in the same cycle as done-with-more.
        step(1, 0, 1, 32'h0000_0001, 0, 0, 0, 0);
        step(1, 0, 1, 32'h0000_0000, 1, 1, 0, 0);
        rd_quick("R9");
        // R9: last transfer clears active while start stays set.
        step(1, 0, 1, 32'h0000_0009, 0, 0, 0, 0);
        step(0, 0, 1, 0, 1, 0, 0, 0);
        rd_quick("R9");
        step(0, 0, 1, 0, 1, 1, 0, 0);
        rd_quick("R9");

        // R11: reset while active cancels and clears everything.
        step(1, 4, 4, 32'hDEAD_BEEF, 0, 0, 1, 1);
        do_reset();
        rd_sweep("R11");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule